// File: doc/BRIEF.md
# Gate A20 and Keyboard Reset Assist

This block sits beside an embedded keyboard controller and takes over two legacy chores from its firmware. It watches host I/O writes (a single-cycle write strobe with a 16-bit address and a byte of data stands in for the host bus). From those writes it drives the Gate A20 output and launches a timed keyboard-reset pulse. Sources are the fast-A20 port, a Gate A20 command sequence and a reset command sequence, each behind its own enable bit.

It also keeps the controller's host-visible status byte. That byte holds the input-full and output-full flags, a command/data marker and firmware-owned flag bits. The block latches the last byte the host wrote to the controller. A control register lets local firmware set the enables and set or clear Gate A20 directly, and read the live Gate A20 level back. Two outputs tell the pin multiplexer when the reset pin or the A20 pin is taken away from general-purpose use.

Top module: `a20_kbrst_assist`

## Requirements
- R1: After chip reset `gate_a20` is 1, `kb_reset` is 1, `kbc_status` is 0x00, `fw_ibuf_data` is 0x00, both GPIO-disable outputs are 0 and `fw_ctl_rdata` reads 0x01.
- R2: A host write to address 0x92 with data bit 1 set drives `gate_a20` to 1 only when control bit 4 (fast-port enable) is 1. When that bit is 0 the write leaves `gate_a20` unchanged.
- R3: With control bit 4 set, a host write to 0x92 with data bit 0 set starts a reset pulse.
- R4: A reset pulse keeps `kb_reset` high for 14×CYC_PER_US cycles after the trigger edge, then low for 6×CYC_PER_US cycles, then high again until the next trigger.
- R5: A trigger that arrives while a pulse is in progress is ignored. It neither restarts nor queues a pulse.
- R6: With control bit 2 set, a host write to the data port (0x60) that directly follows a command-port (0x64) write of 0xD1 drives `gate_a20` to 1. Any other command written in between cancels the pending 0xD1, and with bit 2 clear the sequence has no effect.
- R7: With control bit 3 set, a data-port write that directly follows a command write of 0xFE starts a reset pulse. Any other command in between cancels it.
- R8: A firmware control write with bit 1 set drives `gate_a20` to 1, and one with bit 0 set drives it to 0. When both are set, or when the clear coincides with a hardware set, the clear wins.
- R9: `fw_ctl_rdata` returns the three enables in bits 4..2, the current `gate_a20` in bit 0 and zero elsewhere.
- R10: A host write to 0x64 sets status bit 3 (command) and bit 1 (input full). A write to 0x60 clears bit 3 and sets bit 1. Either write latches the byte on `fw_ibuf_data`. `fw_ibuf_rd` clears bit 1, and a host write in the same cycle wins.
- R11: `fw_sts_wr` loads status bits 7..4, 2 and 0 (output full) from its data. Bits 3 and 1 are not affected by it.
- R12: While `hbus_rst_n` is low, status bits 3 and 1 and any pending command are cleared, `gate_a20` is 1 and host writes are ignored. The enables and firmware flag bits are kept.
- R13: `rst_gpio_off` equals control bit 3. `a20_gpio_off` is 1 when control bit 2 or bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| hbus_rst_n | input | 1 | Host bus reset, synchronous level, active low |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| fw_ctl_wr | input | 1 | Firmware write to the control register |
| fw_ctl_wdata | input | 8 | Firmware control write data |
| fw_ctl_rdata | output | 8 | Control register read value |
| fw_sts_wr | input | 1 | Firmware write to the status flags |
| fw_sts_wdata | input | 8 | Firmware status write data |
| fw_ibuf_rd | input | 1 | Firmware read of the input buffer |
| fw_ibuf_data | output | 8 | Last byte the host wrote to 0x60 or 0x64 |
| kbc_status | output | 8 | Host-visible status byte |
| gate_a20 | output | 1 | Gate A20 level |
| kb_reset | output | 1 | Keyboard reset pin level, idle high |
| a20_gpio_off | output | 1 | A20 pin taken from general-purpose use |
| rst_gpio_off | output | 1 | Reset pin taken from general-purpose use |

## Verification
Firmware clearing Gate A20 and the host setting it through the fast port can fall in the same clock. The bench drives a control write with bit 0 set and a 0x92 write with bit 1 set on one edge. It expects `gate_a20` low in the following cycle, and then a lone 0x92 write shows the set path still works. A host data write that coincides with a firmware input-buffer read is provoked the same way, and the input-full flag must stay set.

// File: rtl/a20rst_pkg.sv
package a20rst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } rst_phase_e;

  typedef struct packed {
    logic fast_en;
    logic hwrst_en;
    logic hwa20_en;
  } ctl_en_t;

  localparam int unsigned CTL_FAST_BIT  = 4;
  localparam int unsigned CTL_HWRST_BIT = 3;
  localparam int unsigned CTL_HWA20_BIT = 2;
  localparam int unsigned CTL_SET_BIT   = 1;
  localparam int unsigned CTL_CLR_BIT   = 0;

  localparam logic [7:0] CMD_GATE = 8'hD1;
  localparam logic [7:0] CMD_RST  = 8'hFE;

endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
  import a20rst_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DATA_ADDR = 'h60,
  parameter int unsigned CMD_ADDR  = 'h64,
  parameter int unsigned FAST_ADDR = 'h92
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          hb_rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  ctl_en_t       en_i,
  input  logic          ibuf_rd_i,
  output logic          ibf_o,
  output logic          cd_o,
  output logic [7:0]    ibuf_o,
  output logic          a20_set_o,
  output logic          rst_trig_o
);

  logic wr_ok, is_data, is_cmd, is_fast;
  logic pend_gate_q, pend_gate_d;
  logic pend_rst_q, pend_rst_d;
  logic ibf_q, ibf_d;
  logic cd_q, cd_d;
  logic [7:0] ibuf_q;
  logic ibuf_en;
  logic pend_en;

  assign wr_ok   = wr_i & hb_rst_ni;
  assign is_data = wr_ok && (addr_i == AW'(DATA_ADDR));
  assign is_cmd  = wr_ok && (addr_i == AW'(CMD_ADDR));
  assign is_fast = wr_ok && (addr_i == AW'(FAST_ADDR));

  assign a20_set_o  = (is_fast && en_i.fast_en && data_i[1]) ||
                      (is_data && pend_gate_q && en_i.hwa20_en);
  assign rst_trig_o = (is_fast && en_i.fast_en && data_i[0]) ||
                      (is_data && pend_rst_q && en_i.hwrst_en);

  assign pend_en = !hb_rst_ni || is_cmd || is_data;
  assign ibuf_en = is_cmd || is_data;

  always_comb begin
    pend_gate_d = 1'b0;
    pend_rst_d  = 1'b0;
    if (hb_rst_ni && is_cmd) begin
      pend_gate_d = (data_i == CMD_GATE);
      pend_rst_d  = (data_i == CMD_RST);
    end
  end

  always_comb begin
    ibf_d = ibf_q;
    cd_d  = cd_q;
    if (!hb_rst_ni) begin
      ibf_d = 1'b0;
      cd_d  = 1'b0;
    end else if (is_cmd) begin
      ibf_d = 1'b1;
      cd_d  = 1'b1;
    end else if (is_data) begin
      ibf_d = 1'b1;
      cd_d  = 1'b0;
    end else if (ibuf_rd_i) begin
      ibf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_gate_q <= 1'b0;
      pend_rst_q  <= 1'b0;
    end else if (pend_en) begin
      pend_gate_q <= pend_gate_d;
      pend_rst_q  <= pend_rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q <= 1'b0;
      cd_q  <= 1'b0;
    end else begin
      ibf_q <= ibf_d;
      cd_q  <= cd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ibuf_q <= 8'h00;
    end else if (ibuf_en) begin
      ibuf_q <= data_i;
    end
  end

  assign ibf_o  = ibf_q;
  assign cd_o   = cd_q;
  assign ibuf_o = ibuf_q;

  AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({pend_gate_q, pend_rst_q})); // R6

  AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && hb_rst_ni && (addr_i == AW'(DATA_ADDR) || addr_i == AW'(CMD_ADDR)))
      |=> ibf_o); // R10

  AST_HBRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    !hb_rst_ni |=> (!ibf_o && !cd_o && !pend_gate_q && !pend_rst_q)); // R12

endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
  input  logic clk,
  input  logic rst_ni,
  input  logic hb_rst_ni,
  input  logic hw_set_i,
  input  logic fw_set_i,
  input  logic fw_clr_i,
  output logic gate_o
);

  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    if (!hb_rst_ni)    gate_d = 1'b1;
    else if (fw_clr_i) gate_d = 1'b0;
    else if (fw_set_i) gate_d = 1'b1;
    else if (hw_set_i) gate_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  AST_HBRST_GATE_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    !hb_rst_ni |=> gate_o); // R12

  AST_FW_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (hb_rst_ni && fw_clr_i) |=> !gate_o); // R8

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (hb_rst_ni && !fw_clr_i && (hw_set_i || fw_set_i)) |=> gate_o); // R2

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (hb_rst_ni && !fw_clr_i && !fw_set_i && !hw_set_i) |=> $stable(gate_o)); // R2

endmodule

// File: rtl/kbrst_pulse_gen.sv
module kbrst_pulse_gen
  import a20rst_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 10,
  parameter int unsigned HI_US      = 14,
  parameter int unsigned LO_US      = 6
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic trig_i,
  output logic kb_rst_o
);

  localparam int unsigned HI_CYC = HI_US * CYC_PER_US;
  localparam int unsigned LO_CYC = LO_US * CYC_PER_US;
  localparam int unsigned MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned CW = $clog2(MAX_CYC + 1);

  rst_phase_e ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (trig_i) begin
          ph_d  = PH_HIGH;
          cnt_d = CW'(HI_CYC - 1);
        end
      end
      PH_HIGH: begin
        if (cnt_zero) begin
          ph_d  = PH_LOW;
          cnt_d = CW'(LO_CYC - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_LOW: begin
        if (cnt_zero) ph_d = PH_IDLE;
        else          cnt_d = cnt_q - CW'(1);
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign kb_rst_o = (ph_q != PH_LOW);

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_IDLE && trig_i) |=> (ph_q == PH_HIGH)); // R3

  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_HIGH && trig_i && !cnt_zero)
      |=> (ph_q == PH_HIGH && cnt_q == $past(cnt_q) - CW'(1))); // R5

  AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(kb_rst_o) |-> ($past(ph_q) == PH_HIGH)); // R4

  AST_LOW_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_LOW) |=> (ph_q == PH_LOW || ph_q == PH_IDLE)); // R4

endmodule

// File: rtl/a20_kbrst_assist.sv
module a20_kbrst_assist
  import a20rst_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DATA_ADDR  = 'h60,
  parameter int unsigned CMD_ADDR   = 'h64,
  parameter int unsigned FAST_ADDR  = 'h92,
  parameter int unsigned CYC_PER_US = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hbus_rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic          fw_ctl_wr,
  input  logic [7:0]    fw_ctl_wdata,
  output logic [7:0]    fw_ctl_rdata,
  input  logic          fw_sts_wr,
  input  logic [7:0]    fw_sts_wdata,
  input  logic          fw_ibuf_rd,
  output logic [7:0]    fw_ibuf_data,
  output logic [7:0]    kbc_status,
  output logic          gate_a20,
  output logic          kb_reset,
  output logic          a20_gpio_off,
  output logic          rst_gpio_off
);

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  ctl_en_t en_q, en_d;
  logic    fw_set, fw_clr;

  always_comb begin
    en_d.fast_en  = fw_ctl_wdata[CTL_FAST_BIT];
    en_d.hwrst_en = fw_ctl_wdata[CTL_HWRST_BIT];
    en_d.hwa20_en = fw_ctl_wdata[CTL_HWA20_BIT];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)         en_q <= '0;
    else if (fw_ctl_wr) en_q <= en_d;
  end

  assign fw_set = fw_ctl_wr & fw_ctl_wdata[CTL_SET_BIT];
  assign fw_clr = fw_ctl_wr & fw_ctl_wdata[CTL_CLR_BIT];

  logic [4:0] usr_q, usr_d;
  logic       obf_q, obf_d;

  always_comb begin
    usr_d = {fw_sts_wdata[7:4], fw_sts_wdata[2]};
    obf_d = fw_sts_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      usr_q <= '0;
      obf_q <= 1'b0;
    end else if (fw_sts_wr) begin
      usr_q <= usr_d;
      obf_q <= obf_d;
    end
  end

  logic sts_wdata_unused;
  assign sts_wdata_unused = ^{fw_sts_wdata[3], fw_sts_wdata[1], fw_ctl_wdata[7:5]};

  logic ibf, cd, a20_set, rst_trig;

  kbc_host_decode #(
    .AW        (AW),
    .DATA_ADDR (DATA_ADDR),
    .CMD_ADDR  (CMD_ADDR),
    .FAST_ADDR (FAST_ADDR)
  ) u_decode (
    .clk        (clk),
    .rst_ni     (rst_s),
    .hb_rst_ni  (hbus_rst_n),
    .wr_i       (host_wr),
    .addr_i     (host_addr),
    .data_i     (host_wdata),
    .en_i       (en_q),
    .ibuf_rd_i  (fw_ibuf_rd),
    .ibf_o      (ibf),
    .cd_o       (cd),
    .ibuf_o     (fw_ibuf_data),
    .a20_set_o  (a20_set),
    .rst_trig_o (rst_trig)
  );

  a20_gate_reg u_gate (
    .clk       (clk),
    .rst_ni    (rst_s),
    .hb_rst_ni (hbus_rst_n),
    .hw_set_i  (a20_set),
    .fw_set_i  (fw_set),
    .fw_clr_i  (fw_clr),
    .gate_o    (gate_a20)
  );

  kbrst_pulse_gen #(
    .CYC_PER_US (CYC_PER_US)
  ) u_pulse (
    .clk      (clk),
    .rst_ni   (rst_s),
    .trig_i   (rst_trig),
    .kb_rst_o (kb_reset)
  );

  assign kbc_status   = {usr_q[4:1], cd, usr_q[0], ibf, obf_q};
  assign fw_ctl_rdata = {3'b000, en_q.fast_en, en_q.hwrst_en, en_q.hwa20_en, 1'b0, gate_a20};
  assign rst_gpio_off = en_q.hwrst_en;
  assign a20_gpio_off = en_q.hwa20_en | en_q.fast_en;

  AST_USER_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !fw_sts_wr |=> ($stable({kbc_status[7:4], kbc_status[2], kbc_status[0]}))); // R11

  AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !fw_ctl_wr |=> $stable(fw_ctl_rdata[4:2])); // R12

endmodule

// File: tb/sim_a20_kbrst_assist.sv
`timescale 1ns/1ps
module sim_a20_kbrst_assist;

  localparam int CPU = 10;
  localparam int HI  = 14 * CPU;
  localparam int LO  = 6 * CPU;

  localparam int S_GATE = 0, S_KBR = 1, S_STS = 2, S_CTL = 3, S_IBUF = 4, S_GPIO = 5;

  logic clk = 1'b0;
  logic rst_n, hbus_rst_n, host_wr, fw_ctl_wr, fw_sts_wr, fw_ibuf_rd;
  logic [15:0] host_addr;
  logic [7:0] host_wdata, fw_ctl_wdata, fw_sts_wdata;
  logic [7:0] fw_ctl_rdata, fw_ibuf_data, kbc_status;
  logic gate_a20, kb_reset, a20_gpio_off, rst_gpio_off;

  always #5 clk = ~clk;

  a20_kbrst_assist #(.CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .hbus_rst_n(hbus_rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .fw_ctl_wr(fw_ctl_wr), .fw_ctl_wdata(fw_ctl_wdata), .fw_ctl_rdata(fw_ctl_rdata),
    .fw_sts_wr(fw_sts_wr), .fw_sts_wdata(fw_sts_wdata),
    .fw_ibuf_rd(fw_ibuf_rd), .fw_ibuf_data(fw_ibuf_data),
    .kbc_status(kbc_status), .gate_a20(gate_a20), .kb_reset(kb_reset),
    .a20_gpio_off(a20_gpio_off), .rst_gpio_off(rst_gpio_off)
  );

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_GATE:  return {7'b0, gate_a20};
      S_KBR:   return {7'b0, kb_reset};
      S_STS:   return kbc_status;
      S_CTL:   return fw_ctl_rdata;
      S_IBUF:  return fw_ibuf_data;
      default: return {6'b0, a20_gpio_off, rst_gpio_off};
    endcase
  endfunction

  // monitor: compares every expected item when its cycle comes up
  always @(negedge clk) begin
    int i;
    i = 0;
    while (i < exp_q.size()) begin
      if (exp_q[i].due == cyc) begin
        logic [7:0] act;
        act = observe(exp_q[i].sel);
        checks++;
        if (act !== exp_q[i].val) begin
          errors++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%02h expected=%02h",
                   exp_q[i].tag, exp_q[i].sel, cyc, act, exp_q[i].val);
        end
        exp_q.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic expect_at(int k, int sel, logic [7:0] val, string tag);
    item_t it;
    it.due = cyc + k; it.sel = sel; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    host_wr = 1'b0; fw_ctl_wr = 1'b0; fw_sts_wr = 1'b0; fw_ibuf_rd = 1'b0;
    hbus_rst_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv_host(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
  endtask

  task automatic drv_ctl(logic [7:0] d);
    @(negedge clk);
    fw_ctl_wr = 1'b1; fw_ctl_wdata = d;
  endtask

  task automatic drv_sts(logic [7:0] d);
    @(negedge clk);
    fw_sts_wr = 1'b1; fw_sts_wdata = d;
  endtask

  task automatic drv_rd();
    @(negedge clk);
    fw_ibuf_rd = 1'b1;
  endtask

  task automatic pulse_expect(string tag);
    expect_at(HI, S_KBR, 8'h01, tag);
    expect_at(HI + 1, S_KBR, 8'h00, tag);
    expect_at(HI + LO, S_KBR, 8'h00, tag);
    expect_at(HI + LO + 1, S_KBR, 8'h01, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hbus_rst_n = 1'b1; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    fw_ctl_wr = 1'b0; fw_ctl_wdata = '0; fw_sts_wr = 1'b0; fw_sts_wdata = '0; fw_ibuf_rd = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    expect_at(1, S_GATE, 8'h01, "R1");
    expect_at(1, S_KBR,  8'h01, "R1");
    expect_at(1, S_STS,  8'h00, "R1");
    expect_at(1, S_IBUF, 8'h00, "R1");
    expect_at(1, S_GPIO, 8'h00, "R1");
    expect_at(1, S_CTL,  8'h01, "R1 R9");
    idle(2);

    // R8 clear, R2 fast port disabled then enabled, R13
    drv_ctl(8'h01); expect_at(1, S_GATE, 8'h00, "R8"); expect_at(1, S_CTL, 8'h00, "R9"); settle();
    drv_host(16'h0092, 8'h02); expect_at(1, S_GATE, 8'h00, "R2 disabled"); settle();
    drv_ctl(8'h10); expect_at(1, S_CTL, 8'h10, "R9"); expect_at(1, S_GPIO, 8'h02, "R13"); settle();
    drv_host(16'h0092, 8'h02); expect_at(1, S_GATE, 8'h01, "R2"); expect_at(1, S_CTL, 8'h11, "R9"); settle();

    // R3 R4 pulse from fast port; R5 retrigger mid-pulse ignored
    drv_host(16'h0092, 8'h01); pulse_expect("R3 R4");
    expect_at(HI + LO + 40, S_KBR, 8'h01, "R5");
    expect_at(1, S_GATE, 8'h01, "R3");
    settle();
    idle(50);
    drv_host(16'h0092, 8'h01); settle();
    idle(HI + LO + 10);

    // R8 set, set+clear, clear vs hardware set
    drv_ctl(8'h11); expect_at(1, S_GATE, 8'h00, "R8"); settle();
    drv_ctl(8'h12); expect_at(1, S_GATE, 8'h01, "R8"); settle();
    drv_ctl(8'h13); expect_at(1, S_GATE, 8'h00, "R8 both"); settle();
    drv_ctl(8'h12); settle();
    @(negedge clk);
    fw_ctl_wr = 1'b1; fw_ctl_wdata = 8'h11;
    host_wr = 1'b1; host_addr = 16'h0092; host_wdata = 8'h02;
    expect_at(1, S_GATE, 8'h00, "R8 clear vs hw set"); settle();
    drv_host(16'h0092, 8'h02); expect_at(1, S_GATE, 8'h01, "R2"); settle();

    // R6 D1 sequence, R10 status
    drv_ctl(8'h05); expect_at(1, S_GATE, 8'h00, "R8"); expect_at(1, S_GPIO, 8'h02, "R13"); settle();
    drv_host(16'h0064, 8'hD1); expect_at(1, S_STS, 8'h0A, "R10 cmd"); expect_at(1, S_IBUF, 8'hD1, "R10"); settle();
    drv_rd(); expect_at(1, S_STS, 8'h08, "R10 read"); settle();
    drv_host(16'h0060, 8'h00); expect_at(1, S_GATE, 8'h01, "R6"); expect_at(1, S_STS, 8'h02, "R10 data");
    expect_at(1, S_IBUF, 8'h00, "R10"); settle();
    drv_ctl(8'h05); settle();
    drv_host(16'h0064, 8'hD1); settle();
    drv_host(16'h0064, 8'hAA); settle();
    drv_host(16'h0060, 8'h00); expect_at(1, S_GATE, 8'h00, "R6 cancel"); settle();
    drv_ctl(8'h00); settle();
    drv_host(16'h0064, 8'hD1); settle();
    drv_host(16'h0060, 8'h00); expect_at(1, S_GATE, 8'h00, "R6 disabled"); settle();

    // R7 FE sequence
    drv_ctl(8'h08); expect_at(1, S_GPIO, 8'h01, "R13"); settle();
    drv_host(16'h0064, 8'hFE); settle();
    drv_host(16'h0060, 8'h00); pulse_expect("R7"); settle();
    idle(HI + LO + 5);
    drv_host(16'h0064, 8'hFE); settle();
    drv_host(16'h0064, 8'h20); settle();
    drv_host(16'h0060, 8'h00); expect_at(HI + 1, S_KBR, 8'h01, "R7 cancel"); settle();
    idle(HI + 5);

    // R10 same-cycle write and read
    drv_rd(); expect_at(1, S_STS, 8'h00, "R10"); settle();
    @(negedge clk);
    host_wr = 1'b1; host_addr = 16'h0060; host_wdata = 8'h5A; fw_ibuf_rd = 1'b1;
    expect_at(1, S_STS, 8'h02, "R10 write wins"); expect_at(1, S_IBUF, 8'h5A, "R10"); settle();

    // R11 firmware flags
    drv_sts(8'hFF); expect_at(1, S_STS, 8'hF7, "R11"); settle();
    drv_rd(); expect_at(1, S_STS, 8'hF5, "R11"); settle();
    drv_sts(8'h00); expect_at(1, S_STS, 8'h00, "R11"); settle();

    // R12 host bus reset
    drv_sts(8'hF4); expect_at(1, S_STS, 8'hF4, "R11"); settle();
    drv_ctl(8'h1D); expect_at(1, S_CTL, 8'h1C, "R9"); expect_at(1, S_GPIO, 8'h03, "R13"); settle();
    drv_host(16'h0064, 8'hD1); expect_at(1, S_STS, 8'hFE, "R10"); settle();
    @(negedge clk); hbus_rst_n = 1'b0;
    expect_at(1, S_GATE, 8'h01, "R12"); expect_at(1, S_STS, 8'hF4, "R12");
    expect_at(1, S_CTL, 8'h1D, "R12"); settle();
    drv_ctl(8'h1D); expect_at(1, S_GATE, 8'h00, "R8"); settle();
    drv_host(16'h0060, 8'h00); expect_at(1, S_GATE, 8'h00, "R12 pending cleared");
    expect_at(1, S_STS, 8'hF6, "R10"); settle();
    @(negedge clk); hbus_rst_n = 1'b0;
    host_wr = 1'b1; host_addr = 16'h0092; host_wdata = 8'h01;
    expect_at(1, S_STS, 8'hF4, "R12"); expect_at(HI + 1, S_KBR, 8'h01, "R12 write ignored");
    settle();

    idle(HI + LO + 20);
    if (exp_q.size() != 0) begin
      foreach (exp_q[i]) begin
        errors++;
        $display("FAIL %s never sampled actual=none expected=%02h", exp_q[i].tag, exp_q[i].val);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule